// File: doc/BRIEF.md
# Rectangle Tiling Transfer Sequencer

This block turns one rectangle request (origin, width, height and a bytes-per-pixel code) into an ordered stream of transfer commands. Together the commands touch every pixel of the rectangle exactly once. The image is stored in fixed 64-byte microtiles, and the size of a microtile in pixels depends on the pixel size. Every microtile that lies entirely inside the rectangle becomes a single whole-microtile command. The pixels left over at the edges become single-pixel commands.

Each command carries a type flag and the x and y coordinates of its first pixel. Commands leave through a valid/ready handshake. A downstream address generator and data mover consume them. When the sequence has ended, a one-cycle done pulse follows. While a sequence is running, the block accepts no new request.

The rectangle is split into an aligned interior and four edge strips. The interior is issued first, as whole microtiles. The strips then follow in a fixed order. If the interior is empty in either direction, the block does not build strips. It walks the whole rectangle pixel by pixel instead.

Top module: `tile_xfer_seq`

## Requirements
- R1: The bpp code selects the microtile size as width x height in pixels. Code 0 gives 8x8, code 1 gives 8x4, code 2 gives 4x4, code 3 gives 4x2 and code 4 gives 2x2. Codes 5 to 7 behave like code 4.
- R2: A whole-microtile command has cmd_utile = 1. Its x coordinate is a multiple of the microtile width and its y coordinate is a multiple of the microtile height. It lies in the interior, which runs from x rounded up to the microtile width up to x+width rounded down to it. The interior runs likewise in y, using the microtile height.
- R3: When the interior is non-empty in both directions, all whole-microtile commands come first. They follow raster order: rows of microtiles outer, stepping by the microtile height, and columns inner, stepping by the microtile width.
- R4: When the interior is empty in either direction, every pixel of the rectangle is issued as a single-pixel command (cmd_utile = 0), rows outer and columns inner. No strip ordering applies.
- R5: After the interior come four single-pixel strips, in this order: top, bottom, left, right. The top strip spans the full width, from y to the aligned y start. The bottom strip spans the full width, from the aligned y end to y+height. The left strip covers the columns left of the interior, and the right strip the columns right of it; both cover only the interior rows. Within each strip, rows are outer and columns inner.
- R6: Across the whole sequence, every pixel of the rectangle is covered exactly once. Every command lies inside the rectangle.
- R7: While cmd_valid is high and cmd_ready is low, cmd_valid and all command fields hold steady until the command is accepted.
- R8: req_ready is high only while no sequence is running. A req_valid given while a sequence runs is ignored: the running sequence carries on unchanged.
- R9: seq_done is high for exactly one cycle: the cycle after the last command is accepted. A request with zero width or zero height issues no commands, and seq_done is high in the cycle after the request is accepted.
- R10: Empty strips are skipped without idle cycles. With cmd_ready held high, a new command appears in every cycle, from the first command to the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and will take a request |
| req_x | input | COORD_W | Rectangle left column |
| req_y | input | COORD_W | Rectangle top row |
| req_w | input | COORD_W | Rectangle width in pixels |
| req_h | input | COORD_W | Rectangle height in pixels |
| req_bpp | input | 3 | Bytes-per-pixel code (see R1) |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_utile | output | 1 | 1 = whole microtile, 0 = single pixel |
| cmd_x | output | COORD_W+1 | Column of the command's first pixel |
| cmd_y | output | COORD_W+1 | Row of the command's first pixel |
| seq_done | output | 1 | One-cycle pulse after the last command |

## Verification
The assertions rely on a consumer that never withdraws cmd_ready in a way that matters to them. They also rely on req_valid being sampled only while the block is idle, so that the rectangle captured at the start stays the reference for the whole run. The bench meets this by changing its inputs only at falling edges. It also gives a disturbing request during a run only while commands are still pending, and drops it before the final handshake. Coordinates are kept small, so that x plus width never exceeds COORD_W+1 bits, which the bounds checks in the checker assume.

// File: rtl/tile_seq_pkg.sv
`timescale 1ns/1ps
package tile_seq_pkg;

  typedef enum logic [2:0] {
    RG_INNER  = 3'd0,
    RG_TOP    = 3'd1,
    RG_BOTTOM = 3'd2,
    RG_LEFT   = 3'd3,
    RG_RIGHT  = 3'd4,
    RG_WHOLE  = 3'd5,
    RG_START  = 3'd6,
    RG_NONE   = 3'd7
  } region_e;

  // log2 of the microtile width in pixels for a bytes-per-pixel code
  function automatic logic [1:0] utile_wlog(input logic [2:0] code);
    case (code)
      3'd0, 3'd1: return 2'd3;
      3'd2, 3'd3: return 2'd2;
      default:    return 2'd1;
    endcase
  endfunction

  // log2 of the microtile height in pixels for a bytes-per-pixel code
  function automatic logic [1:0] utile_hlog(input logic [2:0] code);
    case (code)
      3'd0:       return 2'd3;
      3'd1, 3'd2: return 2'd2;
      default:    return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/tile_seq_geom.sv
`timescale 1ns/1ps
module tile_seq_geom
  import tile_seq_pkg::*;
#(
  parameter int X_W = 9
) (
  input  logic [X_W-1:0]       x1,
  input  logic [X_W-1:0]       y1,
  input  logic [X_W-1:0]       x2,
  input  logic [X_W-1:0]       y2,
  input  logic [2:0]           bpp,
  output logic [7:0][X_W-1:0]  rg_xs,
  output logic [7:0][X_W-1:0]  rg_xe,
  output logic [7:0][X_W-1:0]  rg_ys,
  output logic [7:0][X_W-1:0]  rg_ye,
  output logic [7:0]           rg_nonempty,
  output logic                 has_inner,
  output logic [X_W-1:0]       step_x,
  output logic [X_W-1:0]       step_y
);

  localparam logic [X_W-1:0] ONE = {{(X_W-1){1'b0}}, 1'b1};

  logic [X_W-1:0] mask_x, mask_y;
  logic [X_W-1:0] ax1, ax2, ay1, ay2;

  assign step_x = ONE << utile_wlog(bpp);
  assign step_y = ONE << utile_hlog(bpp);
  assign mask_x = step_x - ONE;
  assign mask_y = step_y - ONE;

  assign ax1 = (x1 + mask_x) & ~mask_x;
  assign ay1 = (y1 + mask_y) & ~mask_y;
  assign ax2 = x2 & ~mask_x;
  assign ay2 = y2 & ~mask_y;

  assign has_inner = (ax1 < ax2) && (ay1 < ay2);

  always_comb begin
    rg_xs = '0;
    rg_xe = '0;
    rg_ys = '0;
    rg_ye = '0;
    rg_xs[RG_INNER]  = ax1; rg_xe[RG_INNER]  = ax2; rg_ys[RG_INNER]  = ay1; rg_ye[RG_INNER]  = ay2;
    rg_xs[RG_TOP]    = x1;  rg_xe[RG_TOP]    = x2;  rg_ys[RG_TOP]    = y1;  rg_ye[RG_TOP]    = ay1;
    rg_xs[RG_BOTTOM] = x1;  rg_xe[RG_BOTTOM] = x2;  rg_ys[RG_BOTTOM] = ay2; rg_ye[RG_BOTTOM] = y2;
    rg_xs[RG_LEFT]   = x1;  rg_xe[RG_LEFT]   = ax1; rg_ys[RG_LEFT]   = ay1; rg_ye[RG_LEFT]   = ay2;
    rg_xs[RG_RIGHT]  = ax2; rg_xe[RG_RIGHT]  = x2;  rg_ys[RG_RIGHT]  = ay1; rg_ye[RG_RIGHT]  = ay2;
    rg_xs[RG_WHOLE]  = x1;  rg_xe[RG_WHOLE]  = x2;  rg_ys[RG_WHOLE]  = y1;  rg_ye[RG_WHOLE]  = y2;
  end

  for (genvar g = 0; g < 8; g++) begin : g_ne
    assign rg_nonempty[g] = (rg_xs[g] < rg_xe[g]) && (rg_ys[g] < rg_ye[g]);
  end

endmodule

// File: rtl/tile_seq_order.sv
`timescale 1ns/1ps
module tile_seq_order
  import tile_seq_pkg::*;
(
  input  region_e    cur,
  input  logic       has_inner,
  input  logic [7:0] nonempty,
  output region_e    nxt
);

  always_comb begin
    nxt = RG_NONE;
    case (cur)
      RG_START: begin
        if (has_inner)               nxt = RG_INNER;
        else if (nonempty[RG_WHOLE]) nxt = RG_WHOLE;
      end
      RG_WHOLE, RG_NONE: nxt = RG_NONE;
      default: begin
        // descending scan so the lowest qualifying strip wins
        for (int k = 4; k >= 1; k--) begin
          if (k > int'(cur) && nonempty[k]) nxt = region_e'(3'(k));
        end
      end
    endcase
  end

endmodule

// File: rtl/tile_xfer_seq.sv
`timescale 1ns/1ps
module tile_xfer_seq
  import tile_seq_pkg::*;
#(
  parameter int COORD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [COORD_W-1:0] req_x,
  input  logic [COORD_W-1:0] req_y,
  input  logic [COORD_W-1:0] req_w,
  input  logic [COORD_W-1:0] req_h,
  input  logic [2:0]         req_bpp,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic               cmd_utile,
  output logic [COORD_W:0]   cmd_x,
  output logic [COORD_W:0]   cmd_y,
  output logic               seq_done
);

  localparam int X_W = COORD_W + 1;
  localparam logic [X_W-1:0] ONE = {{(X_W-1){1'b0}}, 1'b1};

  logic           busy_q, done_q;
  region_e        region_q;
  logic [X_W-1:0] cx_q, cy_q;
  logic [X_W-1:0] x1_q, y1_q, x2_q, y2_q;
  logic [2:0]     bpp_q;

  // geometry source: live request while idle, captured copy while busy
  logic [X_W-1:0] g_x1, g_y1, g_x2, g_y2;
  logic [2:0]     g_bpp;
  assign g_x1  = busy_q ? x1_q : {1'b0, req_x};
  assign g_y1  = busy_q ? y1_q : {1'b0, req_y};
  assign g_x2  = busy_q ? x2_q : ({1'b0, req_x} + {1'b0, req_w});
  assign g_y2  = busy_q ? y2_q : ({1'b0, req_y} + {1'b0, req_h});
  assign g_bpp = busy_q ? bpp_q : req_bpp;

  logic [7:0][X_W-1:0] rg_xs, rg_xe, rg_ys, rg_ye;
  logic [7:0]          rg_nonempty;
  logic                has_inner;
  logic [X_W-1:0]      step_x, step_y;

  tile_seq_geom #(.X_W(X_W)) geom_i (
    .x1(g_x1), .y1(g_y1), .x2(g_x2), .y2(g_y2), .bpp(g_bpp),
    .rg_xs(rg_xs), .rg_xe(rg_xe), .rg_ys(rg_ys), .rg_ye(rg_ye),
    .rg_nonempty(rg_nonempty), .has_inner(has_inner),
    .step_x(step_x), .step_y(step_y)
  );

  region_e order_cur, nxt;
  assign order_cur = busy_q ? region_q : RG_START;

  tile_seq_order order_i (
    .cur(order_cur), .has_inner(has_inner), .nonempty(rg_nonempty), .nxt(nxt)
  );

  // walker step within the current region
  logic [X_W-1:0] stx, sty;
  logic [X_W:0]   nx_w, ny_w;
  logic           row_end;
  assign stx     = (region_q == RG_INNER) ? step_x : ONE;
  assign sty     = (region_q == RG_INNER) ? step_y : ONE;
  assign nx_w    = {1'b0, cx_q} + {1'b0, stx};
  assign ny_w    = {1'b0, cy_q} + {1'b0, sty};
  assign row_end = nx_w >= {1'b0, rg_xe[region_q]};

  // named events, also used by the bound checker
  logic ev_start, ev_accept, ev_region_end, ev_last;
  assign ev_start      = req_valid && !busy_q;
  assign ev_accept     = busy_q && cmd_ready;
  assign ev_region_end = ev_accept && row_end && (ny_w >= {1'b0, rg_ye[region_q]});
  assign ev_last       = ev_region_end && (nxt == RG_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      region_q <= RG_NONE;
      cx_q     <= '0;
      cy_q     <= '0;
      x1_q     <= '0;
      y1_q     <= '0;
      x2_q     <= '0;
      y2_q     <= '0;
      bpp_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (ev_start) begin
        x1_q  <= g_x1;
        y1_q  <= g_y1;
        x2_q  <= g_x2;
        y2_q  <= g_y2;
        bpp_q <= g_bpp;
        if (nxt == RG_NONE) begin
          done_q <= 1'b1;
        end else begin
          busy_q   <= 1'b1;
          region_q <= nxt;
          cx_q     <= rg_xs[nxt];
          cy_q     <= rg_ys[nxt];
        end
      end else if (ev_accept) begin
        if (!row_end) begin
          cx_q <= nx_w[X_W-1:0];
        end else if (!ev_region_end) begin
          cx_q <= rg_xs[region_q];
          cy_q <= ny_w[X_W-1:0];
        end else if (ev_last) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          region_q <= RG_NONE;
        end else begin
          region_q <= nxt;
          cx_q     <= rg_xs[nxt];
          cy_q     <= rg_ys[nxt];
        end
      end
    end
  end

  assign req_ready = !busy_q;
  assign cmd_valid = busy_q;
  assign cmd_utile = busy_q && (region_q == RG_INNER);
  assign cmd_x     = cx_q;
  assign cmd_y     = cy_q;
  assign seq_done  = done_q;

endmodule

// File: rtl/tile_xfer_seq_chk.sv
`timescale 1ns/1ps
module tile_xfer_seq_chk
  import tile_seq_pkg::*;
#(
  parameter int COORD_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic [COORD_W-1:0] req_x,
  input logic [COORD_W-1:0] req_y,
  input logic [COORD_W-1:0] req_w,
  input logic [COORD_W-1:0] req_h,
  input logic [2:0]         req_bpp,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic               cmd_utile,
  input logic [COORD_W:0]   cmd_x,
  input logic [COORD_W:0]   cmd_y,
  input logic               seq_done,
  input logic               ev_start,
  input logic               ev_accept,
  input logic               ev_last
);

  localparam int X_W = COORD_W + 1;
  localparam logic [X_W-1:0] ONE = {{(X_W-1){1'b0}}, 1'b1};

  logic [X_W-1:0] cap_x1, cap_y1, cap_x2, cap_y2;
  logic [2:0]     cap_bpp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_x1 <= '0; cap_y1 <= '0; cap_x2 <= '0; cap_y2 <= '0; cap_bpp <= '0;
    end else if (ev_start) begin
      cap_x1  <= {1'b0, req_x};
      cap_y1  <= {1'b0, req_y};
      cap_x2  <= {1'b0, req_x} + {1'b0, req_w};
      cap_y2  <= {1'b0, req_y} + {1'b0, req_h};
      cap_bpp <= req_bpp;
    end
  end

  logic [X_W-1:0] align_mx, align_my;
  assign align_mx = (ONE << utile_wlog(cap_bpp)) - ONE;
  assign align_my = (ONE << utile_hlog(cap_bpp)) - ONE;

  assert_utile_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_utile |-> ((cmd_x & align_mx) == '0) && ((cmd_y & align_my) == '0));

  assert_in_rect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_x >= cap_x1) && (cmd_x < cap_x2) && (cmd_y >= cap_y1) && (cmd_y < cap_y2));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_x) && $stable(cmd_y) && $stable(cmd_utile));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> seq_done && !cmd_valid);

  assert_no_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && !ev_last |=> cmd_valid);

endmodule

bind tile_xfer_seq tile_xfer_seq_chk #(.COORD_W(COORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .req_x(req_x), .req_y(req_y), .req_w(req_w), .req_h(req_h), .req_bpp(req_bpp),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_utile(cmd_utile),
  .cmd_x(cmd_x), .cmd_y(cmd_y), .seq_done(seq_done),
  .ev_start(ev_start), .ev_accept(ev_accept), .ev_last(ev_last)
);

// File: tb/tile_xfer_seq_tb.sv
`timescale 1ns/1ps
module tile_xfer_seq_tb_top;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [CW-1:0] req_x = '0, req_y = '0, req_w = '0, req_h = '0;
  logic [2:0]    req_bpp = '0;
  logic          cmd_valid;
  logic          cmd_ready = 1'b0;
  logic          cmd_utile;
  logic [CW:0]   cmd_x, cmd_y;
  logic          seq_done;

  tile_xfer_seq #(.COORD_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_x(req_x), .req_y(req_y), .req_w(req_w), .req_h(req_h), .req_bpp(req_bpp),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_utile(cmd_utile),
    .cmd_x(cmd_x), .cmd_y(cmd_y), .seq_done(seq_done)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int gcyc = 0;

  int exp_u [1024];
  int exp_x [1024];
  int exp_y [1024];
  int exp_n;
  int uw_g, uh_g;
  logic [63:0] cov [64];

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    gcyc <= gcyc + 1;
    if (gcyc == 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R9: actual %0d expected %0d", gcyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic push(input int u, input int x, input int y);
    exp_u[exp_n] = u; exp_x[exp_n] = x; exp_y[exp_n] = y;
    exp_n++;
  endtask

  task automatic pix_box(input int xa, input int xb, input int ya, input int yb);
    for (int yy = ya; yy < yb; yy++)
      for (int xx = xa; xx < xb; xx++)
        push(0, xx, yy);
  endtask

  // R1 table restated by byte count; R2..R5 layout restated with division
  task automatic build_exp(input int x, input int y, input int w, input int h, input int code);
    int bytes, x2, y2, ax1, ax2, ay1, ay2;
    bytes = (code >= 4) ? 16 : (1 << code);
    uw_g  = (bytes <= 2) ? 8 : (bytes <= 8) ? 4 : 2;
    uh_g  = (bytes == 1) ? 8 : (bytes <= 4) ? 4 : 2;
    x2 = x + w; y2 = y + h;
    ax1 = ((x + uw_g - 1) / uw_g) * uw_g;
    ay1 = ((y + uh_g - 1) / uh_g) * uh_g;
    ax2 = (x2 / uw_g) * uw_g;
    ay2 = (y2 / uh_g) * uh_g;
    exp_n = 0;
    if (w == 0 || h == 0) return;
    if (ax1 < ax2 && ay1 < ay2) begin
      for (int yy = ay1; yy < ay2; yy += uh_g)
        for (int xx = ax1; xx < ax2; xx += uw_g)
          push(1, xx, yy);
      pix_box(x, x2, y, ay1);
      pix_box(x, x2, ay2, y2);
      pix_box(x, ax1, ay1, ay2);
      pix_box(ax2, x2, ay1, ay2);
    end else begin
      pix_box(x, x2, y, y2);
    end
  endtask

  int utile_seen;

  task automatic run_rect(input int x, input int y, input int w, input int h, input int code,
                          input bit stall, input bit disturb);
    int got, cyc, dup, covered;
    bit prev_acc, prev_stall, finished, rdy;
    int hx, hy, hu;
    build_exp(x, y, w, h, code);
    for (int i = 0; i < 64; i++) cov[i] = '0;
    utile_seen = 0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R8 req_ready idle", int'(req_ready), 1);
    req_x = CW'(x); req_y = CW'(y); req_w = CW'(w); req_h = CW'(h); req_bpp = 3'(code);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got = 0; cyc = 0; dup = 0; prev_acc = 0; prev_stall = 0; finished = 0;
    hx = 0; hy = 0; hu = 0;
    while (!finished) begin
      cyc++;
      if (seq_done === 1'b1) begin
        chk(got == exp_n, "R6 R9 command count at done", got, exp_n);
        chk((exp_n == 0) ? (cyc == 1) : prev_acc, "R9 done timing", cyc, exp_n + 1);
        chk(cmd_valid === 1'b0, "R9 no command with done", int'(cmd_valid), 0);
        if (!stall) chk(cyc == exp_n + 1, "R10 back-to-back cycles", cyc, exp_n + 1);
        finished = 1;
      end else begin
        if (prev_stall)
          chk(cmd_valid === 1'b1 && int'(cmd_x) == hx && int'(cmd_y) == hy && int'(cmd_utile) == hu,
              "R7 hold under stall", int'(cmd_x) * 1000 + int'(cmd_y), hx * 1000 + hy);
        rdy = stall ? ((gcyc % 3) != 0) : 1'b1;
        cmd_ready = rdy;
        if (disturb) begin
          req_valid = (got + 1 < exp_n);
          req_x = 8'd1; req_y = 8'd2; req_w = 8'd3; req_h = 8'd4; req_bpp = 3'd2;
          if (cmd_valid === 1'b1) chk(req_ready === 1'b0, "R8 busy refuses", int'(req_ready), 0);
        end
        if (cmd_valid === 1'b1 && rdy) begin
          if (got < exp_n)
            chk(int'(cmd_utile) == exp_u[got] && int'(cmd_x) == exp_x[got] && int'(cmd_y) == exp_y[got],
                "R2 R3 R4 R5 command order",
                int'(cmd_utile) * 1000000 + int'(cmd_x) * 1000 + int'(cmd_y),
                exp_u[got] * 1000000 + exp_x[got] * 1000 + exp_y[got]);
          else
            chk(1'b0, "R6 extra command", got + 1, exp_n);
          if (cmd_utile === 1'b1) utile_seen++;
          for (int dy = 0; dy < ((cmd_utile === 1'b1) ? uh_g : 1); dy++)
            for (int dx = 0; dx < ((cmd_utile === 1'b1) ? uw_g : 1); dx++) begin
              int px, py;
              px = int'(cmd_x) + dx; py = int'(cmd_y) + dy;
              if (px < 64 && py < 64) begin
                if (cov[py][px]) dup++;
                cov[py][px] = 1'b1;
              end
            end
          got++;
          prev_acc = 1;
        end else begin
          prev_acc = 0;
        end
        prev_stall = (cmd_valid === 1'b1) && !rdy;
        hx = int'(cmd_x); hy = int'(cmd_y); hu = int'(cmd_utile);
        if (cyc > 4000) begin
          chk(1'b0, "R9 sequence timeout", cyc, exp_n + 1);
          finished = 1;
        end
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    covered = 0;
    for (int yy = y; yy < y + h; yy++)
      for (int xx = x; xx < x + w; xx++)
        if (cov[yy][xx]) covered++;
    chk(dup == 0, "R6 no pixel twice", dup, 0);
    chk(covered == w * h, "R6 all pixels covered", covered, w * h);
    @(negedge clk);
    chk(seq_done === 1'b0, "R9 done lasts one cycle", int'(seq_done), 0);
    cmd_ready = 1'b0;
  endtask

  initial begin
    int xs [3] = '{0, 3, 6};
    int ys [3] = '{0, 1, 7};
    int ws [5] = '{0, 1, 5, 9, 17};
    int hs [5] = '{0, 2, 4, 9, 12};
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && cmd_valid === 1'b0 && seq_done === 1'b0, "R8 reset state",
        int'(req_ready) * 100 + int'(cmd_valid) * 10 + int'(seq_done), 100);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: one 16x16 aligned rectangle per code; utile count reveals the size
    for (int c = 0; c < 8; c++) begin
      int bytes, ew, eh;
      bytes = (c >= 4) ? 16 : (1 << c);
      ew = 128 / (bytes * ((bytes == 1) ? 8 : (bytes <= 4) ? 4 : 2));
      eh = (bytes == 1) ? 8 : (bytes <= 4) ? 4 : 2;
      ew = 64 / (bytes * eh);
      run_rect(0, 0, 16, 16, c, 1'b0, 1'b0);
      chk(utile_seen == (16 / ew) * (16 / eh), "R1 microtile size", utile_seen, (16 / ew) * (16 / eh));
    end

    // R8: disturbing request while busy, R10: gap-free stream
    run_rect(3, 1, 17, 12, 2, 1'b0, 1'b1);
    run_rect(5, 3, 9, 9, 0, 1'b0, 1'b0);

    // R2..R7, R9: sweep of origins, sizes and codes under backpressure
    for (int c = 0; c < 5; c++)
      for (int ix = 0; ix < 3; ix++)
        for (int iy = 0; iy < 3; iy++)
          for (int iw = 0; iw < 5; iw++)
            for (int ih = 0; ih < 5; ih++)
              run_rect(xs[ix], ys[iy], ws[iw], hs[ih], c, 1'b1, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule